// File: doc/BRIEF.md
# NAND Block Usage Policy Monitor

This block sits beside a NAND flash command path and watches every array operation issued to a small device. Each event carries an operation (read, program or erase), a block number, a page number and the pass/fail status bit returned after the operation. From this stream the monitor keeps a state record for each block. The record holds the reads since the last erase, the next page that may be programmed, and how often the most recently programmed page has been written.

The monitor requests relocation of a block's data in two cases: when reads since the last erase pass a disturb limit, and when a program operation fails. These requests wait in a small queue and are held until the consumer acknowledges them. The monitor flags, with a code, any program that breaks the ascending-page rule, passes the partial-program allowance, or addresses a page beyond the block. A failed program or erase marks the block bad, and later events to a bad block are rejected. The mode input selects between one-bit-per-cell and two-bit-per-cell rules: disturb limit, pages per block and partial-program allowance.

Top module: `nand_block_monitor`

## Requirements
- R1: After reset, reloc_valid_o and viol_o are 0, viol_code_o is 0 and bad_map_o is all zeros.
- R2: A read (ev_op_i = 1) to a good block whose read count since erase already equals the mode's limit (RD_LIM_SLC when mlc_i = 0, RD_LIM_MLC when mlc_i = 1) queues a relocation request for that block. That is, the request is raised by the read that takes the count past the limit, and only once per erase interval.
- R3: An erase (ev_op_i = 3) of a good block clears its read count, its next expected page and its partial-program count.
- R4: A program (ev_op_i = 2) to a page other than the next expected page, and other than a repeat of the last programmed page, raises viol_code_o = 2 (order) and leaves page tracking unchanged.
- R5: A program to a page at or beyond the block's page count (64 when mlc_i = 0, 128 when mlc_i = 1) raises viol_code_o = 4 (range).
- R6: Repeating the last programmed page is allowed while its total program count stays within 4 in SLC mode and 1 in MLC mode. Beyond that the program raises viol_code_o = 3 (partial limit).
- R7: A program with ev_fail_i = 1 marks the block bad and queues a relocation request for it. An erase with ev_fail_i = 1 marks the block bad and queues nothing.
- R8: ev_fail_i on a read has no effect: bad_map_o is unchanged.
- R9: Any event to a block already set in bad_map_o raises viol_code_o = 1 and changes none of that block's counters. Bad bits stay set until reset.
- R10: Relocation requests leave in arrival order on reloc_block_o. Each is held with reloc_valid_o = 1 until a cycle with reloc_ack_i = 1 removes it.
- R11: A relocation request that arrives when the queue holds RELOC_DEPTH entries and no entry is leaving that cycle is dropped. If the event has no other violation, it raises viol_code_o = 5.
- R12: viol_o and viol_code_o are registered and describe the event sampled at the previous clock edge. Priority is code 1, then 4, then 2, then 3, then 5. viol_o = 0 with code 0 when there is no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mlc_i | input | 1 | 1 selects two-bit-per-cell rules, 0 one-bit-per-cell |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_op_i | input | 2 | 0 idle, 1 read, 2 program, 3 erase |
| ev_block_i | input | BLK_W | Target block |
| ev_page_i | input | PAGE_W | Target page |
| ev_fail_i | input | 1 | Status fail bit returned by the device |
| reloc_ack_i | input | 1 | Consumes the head relocation request |
| reloc_valid_o | output | 1 | A relocation request is pending |
| reloc_block_o | output | BLK_W | Block of the head relocation request |
| viol_o | output | 1 | Policy violation for the previous event |
| viol_code_o | output | 3 | Violation code |
| bad_map_o | output | NUM_BLOCKS | One bit per block, set when bad |

## Verification
The bench targets the read that lands exactly on the disturb limit in both modes. An off-by-one compare would relocate one read early or late, or relocate again on every later read. It replays reads after an erase to catch a count that is never cleared. It repeats the last page up to and past the partial allowance in each mode, and steps backwards and beyond the page range, so that swapped priorities or a shared counter show up as a wrong code. It fills the relocation queue with program failures while holding acknowledge low. A queue that overwrote or reordered entries, or failed to report the drop, would present the wrong block or miss code 5.

// File: rtl/nand_mon_pkg.sv
package nand_mon_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } nand_op_e;

  typedef enum logic [2:0] {
    VC_NONE    = 3'd0,
    VC_BAD_BLK = 3'd1,
    VC_ORDER   = 3'd2,
    VC_PARTIAL = 3'd3,
    VC_RANGE   = 3'd4,
    VC_QFULL   = 3'd5
  } viol_code_e;
endpackage

// File: rtl/nand_reloc_fifo.sv
module nand_reloc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         ack_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         room_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_ptr_q];
  assign pop     = valid_o & ack_i;
  assign room_o  = (cnt_q < CW'(DEPTH)) | pop;

  function automatic logic [AW-1:0] inc_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_ptr_q] <= data_i;
        wr_ptr_q        <= inc_ptr(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= inc_ptr(rd_ptr_q);
      if (push_i && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R11: never accept a push without space
  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ((cnt_q < CW'(DEPTH)) || pop));

  // R10: head held until acknowledged
  a_r10_hold_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/nand_blk_table.sv
module nand_blk_table #(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_W      = 4,
  parameter int CNT_W      = 20,
  parameter int NP_W       = 8,
  parameter int PART_W     = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BLK_W-1:0]      sel_i,
  input  logic                  we_i,
  input  logic [CNT_W-1:0]      rd_cnt_d_i,
  input  logic [NP_W-1:0]       nxt_pg_d_i,
  input  logic [PART_W-1:0]     part_d_i,
  input  logic                  set_bad_i,
  output logic [CNT_W-1:0]      rd_cnt_o,
  output logic [NP_W-1:0]       nxt_pg_o,
  output logic [PART_W-1:0]     part_o,
  output logic                  bad_o,
  output logic [NUM_BLOCKS-1:0] bad_map_o
);
  logic [CNT_W-1:0]      rd_cnt_q [NUM_BLOCKS];
  logic [NP_W-1:0]       nxt_pg_q [NUM_BLOCKS];
  logic [PART_W-1:0]     part_q   [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] bad_q;

  assign rd_cnt_o  = rd_cnt_q[sel_i];
  assign nxt_pg_o  = nxt_pg_q[sel_i];
  assign part_o    = part_q[sel_i];
  assign bad_o     = bad_q[sel_i];
  assign bad_map_o = bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        rd_cnt_q[i] <= '0;
        nxt_pg_q[i] <= '0;
        part_q[i]   <= '0;
      end
      bad_q <= '0;
    end else begin
      if (we_i) begin
        rd_cnt_q[sel_i] <= rd_cnt_d_i;
        nxt_pg_q[sel_i] <= nxt_pg_d_i;
        part_q[sel_i]   <= part_d_i;
      end
      if (set_bad_i) bad_q[sel_i] <= 1'b1;
    end
  end

  // R9: bad bits are sticky
  a_r9_bad_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((bad_q & $past(bad_q)) == $past(bad_q)));

  // R9: no counter write for an already-bad block
  a_r9_bad_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |-> !we_i);
endmodule

// File: rtl/nand_policy_eval.sv
module nand_policy_eval
  import nand_mon_pkg::*;
#(
  parameter int RD_LIM_SLC  = 1000000,
  parameter int RD_LIM_MLC  = 100000,
  parameter int SLC_PAGES   = 64,
  parameter int MLC_PAGES   = 128,
  parameter int SLC_PARTIAL = 4,
  parameter int MLC_PARTIAL = 1,
  parameter int CNT_W       = 20,
  parameter int NP_W        = 8,
  parameter int PART_W      = 3,
  parameter int PAGE_W      = 7
) (
  input  logic              ev_valid_i,
  input  nand_op_e          ev_op_i,
  input  logic [PAGE_W-1:0] ev_page_i,
  input  logic              ev_fail_i,
  input  logic              mlc_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic [NP_W-1:0]   nxt_pg_i,
  input  logic [PART_W-1:0] part_i,
  input  logic              bad_i,
  input  logic              q_room_i,
  output logic              we_o,
  output logic [CNT_W-1:0]  rd_cnt_d_o,
  output logic [NP_W-1:0]   nxt_pg_d_o,
  output logic [PART_W-1:0] part_d_o,
  output logic              set_bad_o,
  output logic              push_o,
  output viol_code_e        code_o
);
  localparam logic [CNT_W-1:0]  LIM_S  = CNT_W'(RD_LIM_SLC);
  localparam logic [CNT_W-1:0]  LIM_M  = CNT_W'(RD_LIM_MLC);
  localparam logic [NP_W-1:0]   PG_S   = NP_W'(SLC_PAGES);
  localparam logic [NP_W-1:0]   PG_M   = NP_W'(MLC_PAGES);
  localparam logic [PART_W-1:0] PART_S = PART_W'(SLC_PARTIAL);
  localparam logic [PART_W-1:0] PART_M = PART_W'(MLC_PARTIAL);

  logic [CNT_W-1:0]  limit;
  logic [NP_W-1:0]   pg_max, pg;
  logic [PART_W-1:0] part_max;
  logic              push_req;
  viol_code_e        pol_code;

  assign limit    = mlc_i ? LIM_M : LIM_S;
  assign pg_max   = mlc_i ? PG_M : PG_S;
  assign part_max = mlc_i ? PART_M : PART_S;
  assign pg       = NP_W'(ev_page_i);

  always_comb begin
    we_o       = 1'b0;
    rd_cnt_d_o = rd_cnt_i;
    nxt_pg_d_o = nxt_pg_i;
    part_d_o   = part_i;
    set_bad_o  = 1'b0;
    push_req   = 1'b0;
    pol_code   = VC_NONE;
    if (ev_valid_i && ev_op_i != OP_IDLE) begin
      if (bad_i) begin
        pol_code = VC_BAD_BLK;
      end else begin
        unique case (ev_op_i)
          OP_READ: begin
            we_o = 1'b1;
            if (rd_cnt_i == limit) push_req = 1'b1;
            if (rd_cnt_i != '1) rd_cnt_d_o = rd_cnt_i + 1'b1;
          end
          OP_PROG: begin
            if (pg >= pg_max) begin
              pol_code = VC_RANGE;
            end else if (pg == nxt_pg_i) begin
              we_o       = 1'b1;
              nxt_pg_d_o = nxt_pg_i + 1'b1;
              part_d_o   = PART_W'(1);
            end else if (nxt_pg_i != '0 && pg == nxt_pg_i - 1'b1) begin
              if (part_i < part_max) begin
                we_o     = 1'b1;
                part_d_o = part_i + 1'b1;
              end else begin
                pol_code = VC_PARTIAL;
              end
            end else begin
              pol_code = VC_ORDER;
            end
            if (ev_fail_i) begin
              set_bad_o = 1'b1;
              push_req  = 1'b1;
            end
          end
          OP_ERASE: begin
            we_o       = 1'b1;
            rd_cnt_d_o = '0;
            nxt_pg_d_o = '0;
            part_d_o   = '0;
            set_bad_o  = ev_fail_i;
          end
          default: ;
        endcase
      end
    end
    push_o = push_req & q_room_i;
    code_o = pol_code;
    if (push_req && !q_room_i && pol_code == VC_NONE) code_o = VC_QFULL;
  end
endmodule

// File: rtl/nand_block_monitor.sv
module nand_block_monitor
  import nand_mon_pkg::*;
#(
  parameter int NUM_BLOCKS  = 16,
  parameter int RD_LIM_SLC  = 1000000,
  parameter int RD_LIM_MLC  = 100000,
  parameter int SLC_PAGES   = 64,
  parameter int MLC_PAGES   = 128,
  parameter int SLC_PARTIAL = 4,
  parameter int MLC_PARTIAL = 1,
  parameter int RELOC_DEPTH = 4,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int PAGE_W = $clog2(MLC_PAGES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mlc_i,
  input  logic                  ev_valid_i,
  input  logic [1:0]            ev_op_i,
  input  logic [BLK_W-1:0]      ev_block_i,
  input  logic [PAGE_W-1:0]     ev_page_i,
  input  logic                  ev_fail_i,
  input  logic                  reloc_ack_i,
  output logic                  reloc_valid_o,
  output logic [BLK_W-1:0]      reloc_block_o,
  output logic                  viol_o,
  output logic [2:0]            viol_code_o,
  output logic [NUM_BLOCKS-1:0] bad_map_o
);
  localparam int LIM_MAX = (RD_LIM_SLC > RD_LIM_MLC) ? RD_LIM_SLC : RD_LIM_MLC;
  localparam int CNT_W   = $clog2(LIM_MAX + 2);
  localparam int NP_W    = $clog2(MLC_PAGES + 1);
  localparam int PART_W  = $clog2(SLC_PARTIAL + 1);

  logic [CNT_W-1:0]  rd_cnt, rd_cnt_d;
  logic [NP_W-1:0]   nxt_pg, nxt_pg_d;
  logic [PART_W-1:0] part, part_d;
  logic              bad, we, set_bad, push, q_room;
  viol_code_e        code;
  logic              viol_q;
  logic [2:0]        code_q;

  nand_blk_table #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .CNT_W(CNT_W),
    .NP_W(NP_W), .PART_W(PART_W)
  ) i_table (
    .clk_i, .rst_ni,
    .sel_i(ev_block_i), .we_i(we),
    .rd_cnt_d_i(rd_cnt_d), .nxt_pg_d_i(nxt_pg_d), .part_d_i(part_d),
    .set_bad_i(set_bad),
    .rd_cnt_o(rd_cnt), .nxt_pg_o(nxt_pg), .part_o(part), .bad_o(bad),
    .bad_map_o(bad_map_o)
  );

  nand_policy_eval #(
    .RD_LIM_SLC(RD_LIM_SLC), .RD_LIM_MLC(RD_LIM_MLC),
    .SLC_PAGES(SLC_PAGES), .MLC_PAGES(MLC_PAGES),
    .SLC_PARTIAL(SLC_PARTIAL), .MLC_PARTIAL(MLC_PARTIAL),
    .CNT_W(CNT_W), .NP_W(NP_W), .PART_W(PART_W), .PAGE_W(PAGE_W)
  ) i_eval (
    .ev_valid_i, .ev_op_i(nand_op_e'(ev_op_i)), .ev_page_i, .ev_fail_i, .mlc_i,
    .rd_cnt_i(rd_cnt), .nxt_pg_i(nxt_pg), .part_i(part), .bad_i(bad),
    .q_room_i(q_room),
    .we_o(we), .rd_cnt_d_o(rd_cnt_d), .nxt_pg_d_o(nxt_pg_d), .part_d_o(part_d),
    .set_bad_o(set_bad), .push_o(push), .code_o(code)
  );

  nand_reloc_fifo #(.DEPTH(RELOC_DEPTH), .W(BLK_W)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(ev_block_i), .ack_i(reloc_ack_i),
    .valid_o(reloc_valid_o), .data_o(reloc_block_o), .room_o(q_room)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      code_q <= '0;
    end else begin
      viol_q <= (code != VC_NONE);
      code_q <= code;
    end
  end

  assign viol_o      = viol_q;
  assign viol_code_o = code_q;

  // R9: events to bad blocks are rejected next cycle
  a_r9_bad_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_op_i != 2'd0 && bad_map_o[ev_block_i])
      |=> (viol_o && viol_code_o == 3'd1));

  // R8: reads never mark a block bad
  a_r8_read_no_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_op_i == 2'd1) |=> $stable(bad_map_o));

  // R7: a program fail on a good block is reflected in the bad map
  a_r7_prog_fail_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_op_i == 2'd2 && ev_fail_i) |=> bad_map_o[$past(ev_block_i)]);
endmodule

// File: tb/test_nand_block_monitor.sv
`timescale 1ns/1ps
module test_nand_block_monitor;
  localparam int NB   = 16;
  localparam int LS   = 20;
  localparam int LM   = 6;
  localparam int DEP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mlc = 1'b0;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_op = 2'd0;
  logic [3:0] ev_block = '0;
  logic [6:0] ev_page = '0;
  logic       ev_fail = 1'b0;
  logic       ack = 1'b0;
  logic       reloc_valid;
  logic [3:0] reloc_block;
  logic       viol;
  logic [2:0] viol_code;
  logic [NB-1:0] bad_map;

  always #2.5 clk = ~clk;

  nand_block_monitor #(
    .NUM_BLOCKS(NB), .RD_LIM_SLC(LS), .RD_LIM_MLC(LM), .RELOC_DEPTH(DEP)
  ) i_nand_block_monitor (
    .clk_i(clk), .rst_ni(rst_n), .mlc_i(mlc),
    .ev_valid_i(ev_valid), .ev_op_i(ev_op), .ev_block_i(ev_block),
    .ev_page_i(ev_page), .ev_fail_i(ev_fail), .reloc_ack_i(ack),
    .reloc_valid_o(reloc_valid), .reloc_block_o(reloc_block),
    .viol_o(viol), .viol_code_o(viol_code), .bad_map_o(bad_map)
  );

  // behavioural reference
  int m_rc [NB];
  int m_np [NB];
  int m_pc [NB];
  logic [NB-1:0] m_bad;
  int m_q [$];
  int m_code;
  int b, pmax, partmax, lim;
  bit pushr, popr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin m_rc[i] = 0; m_np[i] = 0; m_pc[i] = 0; end
      m_bad = '0; m_q.delete(); m_code = 0;
    end else begin
      popr = (m_q.size() > 0) && ack;
      pushr = 0; m_code = 0; b = int'(ev_block);
      if (ev_valid && ev_op != 2'd0) begin
        if (m_bad[b]) m_code = 1;
        else if (ev_op == 2'd1) begin
          lim = mlc ? LM : LS;
          if (m_rc[b] == lim) pushr = 1;
          m_rc[b]++;
        end else if (ev_op == 2'd2) begin
          pmax = mlc ? 128 : 64; partmax = mlc ? 1 : 4;
          if (int'(ev_page) >= pmax) m_code = 4;
          else if (int'(ev_page) == m_np[b]) begin m_np[b]++; m_pc[b] = 1; end
          else if (m_np[b] > 0 && int'(ev_page) == m_np[b] - 1) begin
            if (m_pc[b] < partmax) m_pc[b]++; else m_code = 3;
          end else m_code = 2;
          if (ev_fail) begin m_bad[b] = 1'b1; pushr = 1; end
        end else begin
          m_rc[b] = 0; m_np[b] = 0; m_pc[b] = 0;
          if (ev_fail) m_bad[b] = 1'b1;
        end
      end
      if (popr) void'(m_q.pop_front());
      if (pushr) begin
        if (m_q.size() < DEP) m_q.push_back(b);
        else if (m_code == 0) m_code = 5;
      end
    end
  end

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("reloc_valid", int'(reloc_valid), int'(m_q.size() > 0));
    if (m_q.size() > 0) chk("reloc_block", int'(reloc_block), m_q[0]);
    chk("viol", int'(viol), int'(m_code != 0));
    chk("viol_code", int'(viol_code), m_code);
    chk("bad_map", int'(bad_map), int'(m_bad));
  end

  task automatic ev(input int op, input int blk, input int pg, input bit fail);
    @(negedge clk);
    ev_valid = 1'b1; ev_op = 2'(op); ev_block = 4'(blk); ev_page = 7'(pg); ev_fail = fail;
    @(negedge clk);
    ev_valid = 1'b0; ev_op = 2'd0; ev_fail = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset reloc_valid", int'(reloc_valid), 0);
    chk("reset viol", int'(viol), 0);
    chk("reset bad_map", int'(bad_map), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cur_req = "R2 R10 SLC limit";
    for (int i = 0; i < LS + 1; i++) ev(1, 3, 0, 0);
    repeat (3) @(negedge clk);
    chk("R2 reloc after limit", int'(reloc_valid), 1);
    chk("R10 held block", int'(reloc_block), 3);
    ev(1, 3, 0, 0);
    do_ack();

    cur_req = "R3 erase clears reads";
    ev(3, 3, 0, 0);
    for (int i = 0; i < LS + 1; i++) ev(1, 3, 0, 0);
    do_ack();

    cur_req = "R2 MLC limit";
    mlc = 1'b1;
    for (int i = 0; i < LM + 2; i++) ev(1, 5, 0, 0);
    do_ack();

    cur_req = "R4 R6 R12 SLC programs";
    mlc = 1'b0;
    ev(2, 1, 0, 0); ev(2, 1, 1, 0); ev(2, 1, 2, 0);
    for (int i = 0; i < 4; i++) ev(2, 1, 2, 0);
    ev(2, 1, 0, 0); ev(2, 1, 5, 0); ev(2, 1, 3, 0);
    cur_req = "R5 range";
    ev(2, 1, 70, 0);
    cur_req = "R3 erase clears pages";
    ev(3, 1, 0, 0); ev(2, 1, 0, 0); ev(2, 1, 1, 0);

    cur_req = "R6 R4 MLC programs";
    mlc = 1'b1;
    ev(2, 2, 0, 0); ev(2, 2, 0, 0); ev(2, 2, 127, 0); ev(2, 2, 1, 0);
    mlc = 1'b0;

    cur_req = "R8 read fail ignored";
    ev(1, 6, 0, 1);
    @(negedge clk);
    chk("R8 bad_map", int'(bad_map[6]), 0);

    cur_req = "R7 fail marking";
    ev(2, 7, 0, 1);
    ev(3, 8, 0, 1);
    @(negedge clk);
    chk("R7 bad bits", int'(bad_map[8:7]), 3);

    cur_req = "R9 bad reject";
    ev(1, 7, 0, 0); ev(3, 7, 0, 0); ev(2, 8, 0, 1);
    do_ack();

    cur_req = "R11 R10 queue full";
    ev(2, 9, 0, 1); ev(2, 10, 0, 1); ev(2, 11, 0, 1);
    @(negedge clk);
    chk("R10 head order", int'(reloc_block), 9);
    do_ack();
    chk("R10 second", int'(reloc_block), 10);
    do_ack();
    repeat (2) @(negedge clk);
    chk("R11 dropped", int'(reloc_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule